// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Interlock

This block is a multiply/divide engine that sits beside a single-cycle integer ALU. A command strobe hands it an operation and two 64-bit operands. It then works through the operation one step per cycle for a fixed number of cycles that depends only on the operation kind. At the end it writes two 64-bit result registers, HI and LO. While the engine runs, the rest of the pipeline keeps going. The unit holds it back in only two cases: an instruction reads HI or LO before the running operation has retired, or a new command arrives before the running one can hand over.

Multiplies accumulate a digit of the multiplier in each step. Divides produce one quotient bit in each restoring step. Both work on operand magnitudes, and the sign is applied when the result is written. Half-width operations (32-bit) take their operands from the low halves of the inputs and sign-extend both results to 64 bits. The stall output is the only handshake. A command counts as taken in a cycle where the strobe is high and the stall output is low.

Top module: `mdu_hilo`

## Requirements
- R1: `op_i` is decoded as follows. Bit 2 selects divide (1) or multiply (0). Bit 1 selects full 64-bit width (1) or 32-bit width (0). Bit 0 selects unsigned (1) or signed (0). A command is taken at a rising edge where `start_i` is 1 and `stall_o` is 0, and `busy_o` is 1 in the cycle after.
- R2: `busy_o` stays high for exactly L cycles after the edge that takes a command. L is 8 for a 32-bit multiply, 12 for a 64-bit multiply, 36 for a 32-bit divide and 68 for a 64-bit divide. HI and LO take the new result at the same edge where `busy_o` falls.
- R3: For a 64-bit multiply, LO receives bits 63:0 and HI receives bits 127:64 of the 128-bit product. The product is signed or unsigned as bit 0 of `op_i` selects.
- R4: A 32-bit multiply uses bits 31:0 of each operand. LO receives product bits 31:0 sign-extended to 64 bits, and HI receives product bits 63:32 sign-extended to 64 bits.
- R5: A divide writes the quotient, truncated toward zero, to LO and the remainder to HI. The remainder takes the sign of the dividend. For 32-bit divides, both results are bits 31:0 sign-extended to 64 bits.
- R6: A request to read HI or LO while `busy_o` is 1 raises `stall_o` in that same cycle. When `busy_o` is 0, `stall_o` is 0 and `hi_o`/`lo_o` hold the last retired result.
- R7: A start request while busy, outside the final busy cycle, raises `stall_o` and is not taken. A request in the final busy cycle, with no read pending, is taken without a stall. Back-to-back commands therefore issue every L cycles.
- R8: HI and LO do not change except at a retirement edge. A read in the same cycle as a taken command is not stalled and returns the previous result.
- R9: A divide by a zero divisor takes the normal latency for its kind and raises no other signal. A 32-bit divisor counts as zero when bits 31:0 of `b_i` are zero.
- R10: After reset, `busy_o` and `stall_o` are 0, and HI and LO read as 0.
- R11: A read request in the final busy cycle stalls the whole stage, so a start request in that cycle is not taken. It is taken in the next cycle, when the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command request |
| op_i | input | 3 | Operation code: divide, full width, unsigned |
| a_i | input | 64 | Multiplicand or dividend |
| b_i | input | 64 | Multiplier or divisor |
| rd_hi_i | input | 1 | Instruction wants to read HI this cycle |
| rd_lo_i | input | 1 | Instruction wants to read LO this cycle |
| busy_o | output | 1 | An operation is in flight |
| stall_o | output | 1 | Hold the issuing stage this cycle |
| hi_o | output | 64 | HI register |
| lo_o | output | 64 | LO register |

## Verification
The risky collision is a retirement and a new event in the same cycle. One case is a held start request that becomes eligible in the final busy cycle, so that the old result lands on the same edge the new command is loaded. The other is a HI/LO read arriving in that final cycle alongside a start, which must stall and push the start one cycle later. The bench provokes both with a start held high across a whole operation. It judges the outcome by the exact per-cycle `stall_o` pattern, by the old result appearing while `busy_o` stays high, and by the second operation's latency. A sweep of corner operands over all eight operation codes checks values and latency against products and quotients the bench computes at 128-bit width.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;
    localparam int OPW  = 3;

    // Field order is the operation code: [2] divide, [1] full width, [0] unsigned.
    typedef struct packed {
        logic is_div;
        logic is_dw;
        logic is_uns;
    } mdu_op_t;

    // What the result formatter needs besides the raw accumulator.
    typedef struct packed {
        mdu_op_t op;
        logic    neg_lo;   // negate product or quotient
        logic    neg_hi;   // negate remainder (divide only)
    } mdu_tag_t;

    function automatic logic [XLEN-1:0] widen_half(input logic [HALF-1:0] v, input logic sgn);
        return {{HALF{sgn & v[HALF-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] cond_neg(input logic [XLEN-1:0] v, input logic n);
        return n ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int LAT_MW = 8,
    parameter int LAT_MD = 12,
    parameter int LAT_DW = 36,
    parameter int LAT_DD = 68
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  mdu_op_t op_i,
    input  logic    rd_hi_i,
    input  logic    rd_lo_i,
    output logic    busy_o,
    output logic    stall_o,
    output logic    accept_o,
    output logic    retire_o
);
    localparam int LMAX01 = (LAT_MW > LAT_MD) ? LAT_MW : LAT_MD;
    localparam int LMAX23 = (LAT_DW > LAT_DD) ? LAT_DW : LAT_DD;
    localparam int LMAX   = (LMAX01 > LMAX23) ? LMAX01 : LMAX23;
    localparam int CW     = $clog2(LMAX + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    function automatic logic [CW-1:0] lat_m1(input mdu_op_t o);
        case ({o.is_div, o.is_dw})
            2'b00:   return CW'(LAT_MW - 1);
            2'b01:   return CW'(LAT_MD - 1);
            2'b10:   return CW'(LAT_DW - 1);
            default: return CW'(LAT_DD - 1);
        endcase
    endfunction

    always_comb begin
        last     = busy_q && (cnt_q == '0);
        stall_o  = busy_q && ((start_i && !last) || rd_hi_i || rd_lo_i);
        accept_o = start_i && !stall_o;
        retire_o = last;
        busy_o   = busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= lat_m1(op_i);
        end else if (last) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_take_R1: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> busy_o);

    assert_idle_free_R6: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !stall_o);

    assert_rise_from_take_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(accept_o));

endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
    import mdu_pkg::*;
#(
    parameter int DIGIT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  mdu_op_t             op_i,
    input  logic [XLEN-1:0]     a_i,
    input  logic [XLEN-1:0]     b_i,
    output logic [2*XLEN-1:0]   acc_o,
    output mdu_tag_t            tag_o,
    output logic                idle_o
);
    localparam int ACCW = 2 * XLEN;
    localparam int PW   = XLEN + DIGIT;
    localparam int SW   = $clog2(XLEN + 1);
    localparam logic [SW-1:0] STEPS_MW = SW'(HALF / DIGIT);
    localparam logic [SW-1:0] STEPS_MD = SW'(XLEN / DIGIT);
    localparam logic [SW-1:0] STEPS_DW = SW'(HALF);
    localparam logic [SW-1:0] STEPS_DD = SW'(XLEN);

    // Operand conditioning: width select, sign detect, magnitude.
    logic [XLEN-1:0] raw [2];
    logic [XLEN-1:0] ext [2];
    logic [XLEN-1:0] mag [2];
    logic            neg [2];

    assign raw[0] = a_i;
    assign raw[1] = b_i;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        assign ext[g] = op_i.is_dw ? raw[g] : widen_half(raw[g][HALF-1:0], ~op_i.is_uns);
        assign neg[g] = ~op_i.is_uns & ext[g][XLEN-1];
        assign mag[g] = cond_neg(ext[g], neg[g]);
    end

    logic [ACCW-1:0] acc_q;
    logic [XLEN-1:0] opnd_q;
    mdu_tag_t        tag_q;
    logic [SW-1:0]   left_q;

    // One multiply step: add opnd * low digit to the upper half, shift right.
    logic [DIGIT-1:0] digit;
    logic [PW-1:0]    pp;
    logic [PW-1:0]    psum;
    logic [ACCW-1:0]  mul_nxt;
    // One restoring divide step: remainder in the upper half, dividend/quotient below.
    logic [XLEN:0]    trial;
    logic [XLEN:0]    diff;
    logic             ge;
    logic [XLEN-1:0]  rem;
    logic [ACCW-1:0]  div_nxt;

    always_comb begin
        digit   = acc_q[DIGIT-1:0];
        pp      = PW'(opnd_q) * PW'(digit);
        psum    = PW'(acc_q[ACCW-1:XLEN]) + pp;
        mul_nxt = {psum, acc_q[XLEN-1:DIGIT]};

        trial   = {acc_q[ACCW-1:XLEN], acc_q[XLEN-1]};
        diff    = trial - {1'b0, opnd_q};
        ge      = ~diff[XLEN];
        rem     = ge ? diff[XLEN-1:0] : trial[XLEN-1:0];
        div_nxt = {rem, acc_q[XLEN-2:0], ge};
    end

    logic [SW-1:0]   steps;
    logic [XLEN-1:0] low_load;

    always_comb begin
        case ({op_i.is_div, op_i.is_dw})
            2'b00:   steps = STEPS_MW;
            2'b01:   steps = STEPS_MD;
            2'b10:   steps = STEPS_DW;
            default: steps = STEPS_DD;
        endcase
        if (op_i.is_div)
            low_load = op_i.is_dw ? mag[0] : {mag[0][HALF-1:0], {HALF{1'b0}}};
        else
            low_load = mag[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            opnd_q <= '0;
            tag_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            acc_q        <= {{XLEN{1'b0}}, low_load};
            opnd_q       <= op_i.is_div ? mag[1] : mag[0];
            tag_q.op     <= op_i;
            tag_q.neg_lo <= neg[0] ^ neg[1];
            tag_q.neg_hi <= op_i.is_div ? neg[0] : (neg[0] ^ neg[1]);
            left_q       <= steps;
        end else if (left_q != '0) begin
            acc_q  <= tag_q.op.is_div ? div_nxt : mul_nxt;
            left_q <= left_q - 1'b1;
        end
    end

    assign acc_o  = acc_q;
    assign tag_o  = tag_q;
    assign idle_o = (left_q == '0);

endmodule

// File: rtl/mdu_format.sv
module mdu_format
    import mdu_pkg::*;
(
    input  logic [2*XLEN-1:0] acc_i,
    input  mdu_tag_t          tag_i,
    output logic [XLEN-1:0]   hi_o,
    output logic [XLEN-1:0]   lo_o
);
    localparam int ACCW = 2 * XLEN;

    logic [ACCW-1:0] full_prod;
    logic [XLEN-1:0] half_prod;
    logic [XLEN-1:0] quo;
    logic [XLEN-1:0] rmd;

    always_comb begin
        // Full-width product occupies the whole accumulator; a half-width one
        // ends up shifted up by HALF because only half the digits were consumed.
        full_prod = tag_i.neg_lo ? (~acc_i + 1'b1) : acc_i;
        half_prod = cond_neg(acc_i[HALF +: XLEN], tag_i.neg_lo);
        quo       = cond_neg(acc_i[XLEN-1:0], tag_i.neg_lo);
        rmd       = cond_neg(acc_i[ACCW-1:XLEN], tag_i.neg_hi);

        case ({tag_i.op.is_div, tag_i.op.is_dw})
            2'b00: begin
                lo_o = widen_half(half_prod[HALF-1:0], 1'b1);
                hi_o = widen_half(half_prod[XLEN-1:HALF], 1'b1);
            end
            2'b01: begin
                lo_o = full_prod[XLEN-1:0];
                hi_o = full_prod[ACCW-1:XLEN];
            end
            2'b10: begin
                lo_o = widen_half(quo[HALF-1:0], 1'b1);
                hi_o = widen_half(rmd[HALF-1:0], 1'b1);
            end
            default: begin
                lo_o = quo;
                hi_o = rmd;
            end
        endcase
    end

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
    import mdu_pkg::*;
#(
    parameter int LAT_MW = 8,
    parameter int LAT_MD = 12,
    parameter int LAT_DW = 36,
    parameter int LAT_DD = 68,
    parameter int DIGIT  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            rd_hi_i,
    input  logic            rd_lo_i,
    output logic            busy_o,
    output logic            stall_o,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);
    mdu_op_t          op;
    logic             accept;
    logic             retire;
    logic             eng_idle;
    logic [2*XLEN-1:0] acc;
    mdu_tag_t         tag;
    logic [XLEN-1:0]  res_hi;
    logic [XLEN-1:0]  res_lo;
    logic [XLEN-1:0]  hi_q;
    logic [XLEN-1:0]  lo_q;

    assign op = mdu_op_t'(op_i);

    mdu_ctrl #(
        .LAT_MW(LAT_MW), .LAT_MD(LAT_MD), .LAT_DW(LAT_DW), .LAT_DD(LAT_DD)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op),
        .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i),
        .busy_o(busy_o), .stall_o(stall_o), .accept_o(accept), .retire_o(retire)
    );

    mdu_engine #(.DIGIT(DIGIT)) u_engine (
        .clk(clk), .rst(rst), .load_i(accept), .op_i(op), .a_i(a_i), .b_i(b_i),
        .acc_o(acc), .tag_o(tag), .idle_o(eng_idle)
    );

    mdu_format u_format (
        .acc_i(acc), .tag_i(tag), .hi_o(res_hi), .lo_o(res_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (retire) begin
            hi_q <= res_hi;
            lo_q <= res_lo;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R2: the iterative engine must have consumed every step before retirement.
    assert_engine_done_R2: assert property (@(posedge clk) disable iff (rst)
        retire |-> eng_idle);

    assert_busy_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(retire));

    assert_hilo_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !retire |=> ($stable(hi_o) && $stable(lo_o)));

endmodule

// File: tb/test_mdu_hilo.sv
module test_mdu_hilo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        rd_hi_i = 1'b0;
    logic        rd_lo_i = 1'b0;
    logic        busy_o, stall_o;
    logic [63:0] hi_o, lo_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mdu_hilo i_mdu_hilo (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i), .busy_o(busy_o), .stall_o(stall_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [2:0] op);
        case (op[2:1])
            2'b00:   return 8;
            2'b01:   return 12;
            2'b10:   return 36;
            default: return 68;
        endcase
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] val(input int k);
        case (k)
            0:  return 64'h0;
            1:  return 64'h1;
            2:  return 64'hFFFF_FFFF_FFFF_FFFF;
            3:  return 64'h7FFF_FFFF_FFFF_FFFF;
            4:  return 64'h8000_0000_0000_0000;
            5:  return 64'h0000_0000_7FFF_FFFF;
            6:  return 64'h0000_0000_8000_0000;
            7:  return 64'hFFFF_FFFF_FFFF_FFF9;
            8:  return 64'h3;
            9:  return 64'h1234_5678_9ABC_DEF0;
            10: return 64'hFEDC_BA98_7654_3211;
            default: return 64'hFFFF_FFFF_0000_0000;
        endcase
    endfunction

    // Arithmetic reference computed at 128-bit signed width (R3, R4, R5).
    task automatic model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] eh, output logic [63:0] el);
        logic [63:0] aw, bw;
        logic signed [127:0] sa, sb, p, q, r;
        if (op[1]) begin
            aw = a; bw = b;
        end else begin
            aw = op[0] ? {32'h0, a[31:0]} : sx(a[31:0]);
            bw = op[0] ? {32'h0, b[31:0]} : sx(b[31:0]);
        end
        sa = op[0] ? {64'h0, aw} : {{64{aw[63]}}, aw};
        sb = op[0] ? {64'h0, bw} : {{64{bw[63]}}, bw};
        eh = '0; el = '0;
        if (!op[2]) begin
            p = sa * sb;
            if (op[1]) begin el = p[63:0]; eh = p[127:64]; end
            else begin el = sx(p[31:0]); eh = sx(p[63:32]); end
        end else if (sb != 0) begin
            q = sa / sb;
            r = sa % sb;
            if (op[1]) begin el = q[63:0]; eh = r[63:0]; end
            else begin el = sx(q[31:0]); eh = sx(r[31:0]); end
        end
    endtask

    // Issue one command from idle and check latency and results.
    task automatic run_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] eh, el;
        int n;
        bit zero_div;
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (busy_o && n < 200) begin
            n++;
            @(negedge clk);
        end
        zero_div = op[2] && ((op[1] ? b : {32'h0, b[31:0]}) == 64'h0);
        chk(n == lat_of(op), zero_div ? "R9 latency" : "R2 latency", n, lat_of(op));
        if (!zero_div) begin
            model(op, a, b, eh, el);
            chk({hi_o, lo_o} == {eh, el},
                op[2] ? "R5 divide" : (op[1] ? "R3 mul64" : "R4 mul32"),
                {hi_o, lo_o}, {eh, el});
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] eh, el;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk(busy_o == 1'b0, "R10 busy", busy_o, 0);
        chk(stall_o == 1'b0, "R10 stall", stall_o, 0);
        chk({hi_o, lo_o} == '0, "R10 hilo", {hi_o, lo_o}, 0);

        // R6: early LO read stalls for every busy cycle, then sees the result
        start_i = 1'b1; op_i = 3'b010; a_i = 64'd5; b_i = 64'd7;
        @(negedge clk);
        start_i = 1'b0; rd_lo_i = 1'b1;
        #1;
        n = 0;
        while (stall_o && n < 200) begin
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == 12, "R6 stall cycles", n, 12);
        chk(lo_o == 64'd35, "R6 read after stall", lo_o, 35);
        chk(busy_o == 1'b0, "R6 idle no stall", {busy_o, stall_o}, 0);
        rd_lo_i = 1'b0;
        @(negedge clk);

        // R8: read in the same cycle as a taken start returns the old result
        start_i = 1'b1; op_i = 3'b000; a_i = -64'sd3; b_i = 64'd4;
        rd_hi_i = 1'b1; rd_lo_i = 1'b1;
        #1;
        chk(stall_o == 1'b0, "R8 no stall on same-cycle read", stall_o, 0);
        chk(lo_o == 64'd35, "R8 old LO visible", lo_o, 35);
        @(negedge clk);
        start_i = 1'b0; rd_hi_i = 1'b0; rd_lo_i = 1'b0;
        chk(busy_o == 1'b1, "R1 busy after take", busy_o, 1);
        repeat (3) @(negedge clk);
        chk(lo_o == 64'd35, "R8 LO held mid-op", lo_o, 35);
        while (busy_o) @(negedge clk);
        chk({hi_o, lo_o} == {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF4},
            "R4 signed mul32", {hi_o, lo_o}, {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF4});

        // R7: start held high across an op is taken in the final busy cycle
        start_i = 1'b1; op_i = 3'b001; a_i = 64'd6; b_i = 64'd7;
        @(negedge clk);
        op_i = 3'b101; a_i = 64'd100; b_i = 64'd7;
        for (int k = 0; k < 8; k++) begin
            #1;
            chk(stall_o == (k < 7), "R7 stall pattern", stall_o, (k < 7));
            @(negedge clk);
        end
        start_i = 1'b0;
        #1;
        chk(busy_o == 1'b1, "R7 busy continuous", busy_o, 1);
        chk(lo_o == 64'd42, "R7 first result retired", lo_o, 42);
        n = 0;
        while (busy_o && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(n == 36, "R7 second latency", n, 36);
        chk({hi_o, lo_o} == {64'd2, 64'd14}, "R5 div32 back-to-back", {hi_o, lo_o}, {64'd2, 64'd14});

        // R11: a read in the final cycle blocks the held start for one cycle
        start_i = 1'b1; op_i = 3'b001; a_i = 64'd9; b_i = 64'd9;
        @(negedge clk);
        op_i = 3'b011; a_i = 64'd2; b_i = 64'd3;
        for (int k = 0; k < 8; k++) begin
            if (k == 7) rd_hi_i = 1'b1;
            #1;
            chk(stall_o == 1'b1, "R11 stall incl final", stall_o, 1);
            @(negedge clk);
        end
        #1;
        chk(busy_o == 1'b0 && stall_o == 1'b0, "R11 idle then take", {busy_o, stall_o}, 0);
        chk(lo_o == 64'd81, "R11 old result", lo_o, 81);
        @(negedge clk);
        start_i = 1'b0; rd_hi_i = 1'b0;
        n = 0;
        while (busy_o && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(n == 12, "R11 delayed op latency", n, 12);
        chk(lo_o == 64'd6, "R11 delayed op result", lo_o, 6);

        // R9: divide by zero, full width
        run_op(3'b111, 64'd77, 64'd0);
        chk(stall_o == 1'b0, "R9 no side effect", stall_o, 0);

        // Sweep: all eight operation codes over a corner-value grid
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run_op(3'(o), val(i), val(j));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule